// File: doc/BRIEF.md
# Double-Buffered PCM Sample Exchange

This block sits between a peripheral bus and the sample side of a speech converter. It moves one 16-bit linear PCM sample in each direction per 8 kHz frame. On the inbound path, a bus master writes a sample into a staging register. A converter-side frame strobe then moves that staged word into a core-facing register, which stays stable for the whole frame. On the outbound path, the same frame strobe captures the converter result into a holding register that the bus reads. Because each path holds two words, the bus has a full 125 µs frame to answer a request before any data is overwritten.

Each frame strobe raises a status flag. That flag feeds an interrupt line and two DMA requests, one per direction, each gated by its own enable. A status read clears the flag. Enabling the interrupt together with either DMA request is not a legal setting. The block detects that setting, records a sticky configuration error, and serves only DMA.

A debug freeze input stops the outbound holding register from being updated. It also stops status reads from clearing the flag, so an emulator can inspect the block without disturbing it.

Top module: `pcm_xchg`

## Requirements
- R1: After reset, `pcm_out_rdata`, `core_in_data`, `stat_flag`, `irq`, `dma_in_req`, `dma_out_req` and `cfg_err` are all 0.
- R2: A write with `pcm_in_we` stores `pcm_in_wdata` in the staging register. `core_in_data` changes only on a cycle with `frame_stb`, and then takes the word that was staged before that edge. A write in the same cycle as the strobe is staged for the next frame.
- R3: A cycle with `frame_stb` high and `freeze` low loads `core_out_data` into `pcm_out_rdata` from the next cycle on.
- R4: While `freeze` is high, `frame_stb` leaves `pcm_out_rdata` unchanged.
- R5: `stat_flag` is set by every `frame_stb`. It is cleared by `stat_re` when `freeze` is low. If the strobe and the read fall in the same cycle, the flag ends up set.
- R6: While `freeze` is high, `stat_re` does not clear `stat_flag`.
- R7: Configuration is written with `cfg_we`, using bit 0 for interrupt enable, bit 1 for inbound DMA enable and bit 2 for outbound DMA enable. For a legal setting, `irq` equals `stat_flag` AND the interrupt enable.
- R8: `dma_in_req` is set by `frame_stb` when inbound DMA is enabled. It is cleared by `pcm_in_we`. If both happen in the same cycle, the request ends up set.
- R9: `dma_out_req` is set by `frame_stb` when outbound DMA is enabled and `freeze` is low. It is cleared by `pcm_out_re`. If both happen in the same cycle, the request ends up set.
- R10: Writing the interrupt enable together with either DMA enable sets `cfg_err`. In that case the interrupt stays disabled and the DMA enables take effect. `cfg_err` stays set until reset, even after a legal setting is written.
- R11: `freeze` has no effect on the inbound path (R2) or on inbound requests (R8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freeze | input | 1 | Debug freeze |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 3 | {out DMA en, in DMA en, int en} |
| pcm_in_we | input | 1 | Bus write of inbound sample |
| pcm_in_wdata | input | 16 | Inbound sample |
| pcm_out_re | input | 1 | Bus read of outbound sample |
| pcm_out_rdata | output | 16 | Outbound holding register |
| stat_re | input | 1 | Bus read of status |
| stat_flag | output | 1 | Frame status flag |
| frame_stb | input | 1 | Converter frame strobe |
| core_out_data | input | 16 | Converter result |
| core_in_data | output | 16 | Sample presented to converter |
| irq | output | 1 | Interrupt request |
| dma_in_req | output | 1 | Inbound DMA request |
| dma_out_req | output | 1 | Outbound DMA request |
| cfg_err | output | 1 | Sticky illegal-configuration flag |

## Verification
A wrong internal state shows up at the ports on the cycle after the edge that caused it, because every output comes straight from a register or from one gate on registers. A staging fault does not appear until the next frame strobe, when `core_in_data` shows the wrong word. Flag and request faults appear within one cycle as a wrong level on `stat_flag`, `irq` or a DMA request. A freeze fault appears either as a change in `pcm_out_rdata` during a frozen strobe, or as a flag that clears during a frozen read.

// File: rtl/pcm_xchg_pkg.sv
package pcm_xchg_pkg;
  localparam int CFG_W = 3;
  localparam int N_DMA = 2;
  localparam int DMA_IN  = 0;
  localparam int DMA_OUT = 1;

  typedef struct packed {
    logic dma_out_en;
    logic dma_in_en;
    logic int_en;
  } cfg_t;
endpackage

// File: rtl/pcm_in_path.sv
module pcm_in_path #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         frame_stb,
  output logic [W-1:0] core_data
);
  logic [W-1:0] stage_q, stage_d;
  logic [W-1:0] core_q, core_d;

  always_comb begin
    stage_d = stage_q;
    core_d  = core_q;
    if (frame_stb) core_d  = stage_q;
    if (wr_en)     stage_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      core_q  <= '0;
    end else begin
      stage_q <= stage_d;
      core_q  <= core_d;
    end
  end

  assign core_data = core_q;
endmodule

// File: rtl/pcm_out_path.sv
module pcm_out_path #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         freeze,
  input  logic         frame_stb,
  input  logic [W-1:0] core_res,
  output logic [W-1:0] rd_data
);
  logic         hold_en;
  logic [W-1:0] hold_q, hold_d;

  assign hold_en = frame_stb && !freeze;

  always_comb begin
    hold_d = hold_q;
    if (hold_en) hold_d = core_res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  assign rd_data = hold_q;
endmodule

// File: rtl/pcm_req_ctrl.sv
module pcm_req_ctrl
  import pcm_xchg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             freeze,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             frame_stb,
  input  logic             stat_re,
  input  logic [N_DMA-1:0] dma_clr,
  output logic             stat_flag,
  output logic             irq,
  output logic [N_DMA-1:0] dma_req,
  output logic             cfg_err
);
  cfg_t cfg_q, cfg_d, cfg_w;
  logic err_q, err_d;
  logic flag_q, flag_d;
  logic illegal;
  logic [N_DMA-1:0] dma_en;
  logic [N_DMA-1:0] dma_set_ok;

  assign cfg_w   = cfg_t'(cfg_wdata);
  assign illegal = cfg_w.int_en && (cfg_w.dma_in_en || cfg_w.dma_out_en);

  always_comb begin
    cfg_d = cfg_q;
    err_d = err_q;
    if (cfg_we) begin
      cfg_d        = cfg_w;
      cfg_d.int_en = cfg_w.int_en && !illegal;
      err_d        = err_q || illegal;
    end
  end

  always_comb begin
    flag_d = flag_q;
    if (stat_re && !freeze) flag_d = 1'b0;
    if (frame_stb)          flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      err_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      err_q  <= err_d;
      flag_q <= flag_d;
    end
  end

  assign dma_en[DMA_IN]      = cfg_q.dma_in_en;
  assign dma_en[DMA_OUT]     = cfg_q.dma_out_en;
  assign dma_set_ok[DMA_IN]  = 1'b1;
  assign dma_set_ok[DMA_OUT] = !freeze;

  for (genvar g = 0; g < N_DMA; g++) begin : g_dma
    logic req_q, req_d;
    always_comb begin
      req_d = req_q;
      if (dma_clr[g])                                req_d = 1'b0;
      if (frame_stb && dma_en[g] && dma_set_ok[g])   req_d = 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= req_d;
    end
    assign dma_req[g] = req_q;
  end

  assign stat_flag = flag_q;
  assign irq       = flag_q && cfg_q.int_en;
  assign cfg_err   = err_q;
endmodule

// File: rtl/pcm_xchg.sv
module pcm_xchg
  import pcm_xchg_pkg::*;
#(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             freeze,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             pcm_in_we,
  input  logic [W-1:0]     pcm_in_wdata,
  input  logic             pcm_out_re,
  output logic [W-1:0]     pcm_out_rdata,
  input  logic             stat_re,
  output logic             stat_flag,
  input  logic             frame_stb,
  input  logic [W-1:0]     core_out_data,
  output logic [W-1:0]     core_in_data,
  output logic             irq,
  output logic             dma_in_req,
  output logic             dma_out_req,
  output logic             cfg_err
);
  logic [N_DMA-1:0] dma_clr;
  logic [N_DMA-1:0] dma_req;

  assign dma_clr[DMA_IN]  = pcm_in_we;
  assign dma_clr[DMA_OUT] = pcm_out_re;

  pcm_in_path #(.W(W)) u_in (
    .clk(clk), .rst_n(rst_n), .wr_en(pcm_in_we), .wr_data(pcm_in_wdata),
    .frame_stb(frame_stb), .core_data(core_in_data)
  );

  pcm_out_path #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .frame_stb(frame_stb),
    .core_res(core_out_data), .rd_data(pcm_out_rdata)
  );

  pcm_req_ctrl u_req (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .frame_stb(frame_stb), .stat_re(stat_re),
    .dma_clr(dma_clr), .stat_flag(stat_flag), .irq(irq),
    .dma_req(dma_req), .cfg_err(cfg_err)
  );

  assign dma_in_req  = dma_req[DMA_IN];
  assign dma_out_req = dma_req[DMA_OUT];
endmodule

// File: rtl/pcm_xchg_chk.sv
module pcm_xchg_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         freeze,
  input logic         frame_stb,
  input logic         stat_re,
  input logic         pcm_in_we,
  input logic         pcm_out_re,
  input logic [W-1:0] pcm_out_rdata,
  input logic [W-1:0] core_in_data,
  input logic         stat_flag,
  input logic         irq,
  input logic         dma_in_req,
  input logic         dma_out_req,
  input logic         cfg_err
);
  a_r2_core_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> $stable(core_in_data));
  a_r4_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && frame_stb) |=> $stable(pcm_out_rdata));
  a_r5_frame_sets: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |=> stat_flag);
  a_r6_freeze_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && stat_flag) |=> stat_flag);
  a_r7_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> stat_flag);
  a_r8_in_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (pcm_in_we && !frame_stb) |=> !dma_in_req);
  a_r9_out_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (pcm_out_re && !frame_stb) |=> !dma_out_req);
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
endmodule

bind pcm_xchg pcm_xchg_chk #(.W(W)) i_chk (
  .clk(clk), .rst_n(rst_n), .freeze(freeze), .frame_stb(frame_stb),
  .stat_re(stat_re), .pcm_in_we(pcm_in_we), .pcm_out_re(pcm_out_re),
  .pcm_out_rdata(pcm_out_rdata), .core_in_data(core_in_data),
  .stat_flag(stat_flag), .irq(irq), .dma_in_req(dma_in_req),
  .dma_out_req(dma_out_req), .cfg_err(cfg_err)
);

// File: tb/test_pcm_xchg.sv
`timescale 1ns/1ps
module test_pcm_xchg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic freeze = 0, cfg_we = 0, pcm_in_we = 0, pcm_out_re = 0, stat_re = 0, frame_stb = 0;
  logic [2:0]  cfg_wdata = '0;
  logic [15:0] pcm_in_wdata = '0, core_out_data = '0;
  logic [15:0] pcm_out_rdata, core_in_data;
  logic stat_flag, irq, dma_in_req, dma_out_req, cfg_err;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [15:0] e_stage = 0, e_core = 0, e_out = 0;
  logic e_flag = 0, e_int = 0, e_din = 0, e_dout = 0, e_err = 0, e_rin = 0, e_rout = 0;

  always #2.5 clk = ~clk;

  pcm_xchg i_pcm_xchg (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .pcm_in_we(pcm_in_we), .pcm_in_wdata(pcm_in_wdata), .pcm_out_re(pcm_out_re),
    .pcm_out_rdata(pcm_out_rdata), .stat_re(stat_re), .stat_flag(stat_flag),
    .frame_stb(frame_stb), .core_out_data(core_out_data), .core_in_data(core_in_data),
    .irq(irq), .dma_in_req(dma_in_req), .dma_out_req(dma_out_req), .cfg_err(cfg_err)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(string out_tag, string flag_tag);
    chk("R2 core_in_data", core_in_data, e_core);
    chk(out_tag, pcm_out_rdata, e_out);
    chk(flag_tag, 16'(stat_flag), 16'(e_flag));
    chk("R7 irq", 16'(irq), 16'(e_flag & e_int));
    chk("R8 dma_in_req", 16'(dma_in_req), 16'(e_rin));
    chk("R9 dma_out_req", 16'(dma_out_req), 16'(e_rout));
    chk("R10 cfg_err", 16'(cfg_err), 16'(e_err));
  endtask

  // one cycle: drive after an edge, model the next edge, check 1ns after it
  task automatic step(logic we, logic [15:0] wd, logic fr, logic [15:0] cr, logic fz,
                      logic sr, logic orr, logic cw, logic [2:0] cd);
    logic ill;
    pcm_in_we = we; pcm_in_wdata = wd; frame_stb = fr; core_out_data = cr;
    freeze = fz; stat_re = sr; pcm_out_re = orr; cfg_we = cw; cfg_wdata = cd;
    @(posedge clk); #1;
    if (fr) e_core = e_stage;
    if (we) e_stage = wd;
    if (fr && !fz) e_out = cr;
    if (fr) e_flag = 1; else if (sr && !fz) e_flag = 0;
    if (fr && e_din) e_rin = 1; else if (we) e_rin = 0;
    if (fr && e_dout && !fz) e_rout = 1; else if (orr) e_rout = 0;
    if (cw) begin
      ill = cd[0] & (cd[1] | cd[2]);
      e_int = cd[0] & ~ill; e_din = cd[1]; e_dout = cd[2]; e_err = e_err | ill;
    end
    pcm_in_we = 0; frame_stb = 0; stat_re = 0; pcm_out_re = 0; cfg_we = 0;
    check_all(fz ? "R4 pcm_out_rdata" : "R3 pcm_out_rdata",
              fz ? "R6 stat_flag" : "R5 stat_flag");
  endtask

  task automatic sweep(int n, int seed);
    for (int i = 0; i < n; i++) begin
      logic [15:0] wd, cr;
      logic [4:0] b;
      wd = 16'(i * 16'h2B1D + seed) ^ 16'h0F0F;
      cr = 16'(i * 16'h7313 + seed) ^ 16'hA5C3;
      b  = 5'(i * 7 + seed);
      // R11: freeze toggles independently of inbound traffic
      step(b[0] | b[3], wd, b[1], cr, b[2], b[3] | b[4], b[4], 1'b0, 3'b000);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_all("R1 pcm_out_rdata", "R1 stat_flag");
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R7: interrupt only
    step(0, 0, 0, 0, 0, 0, 0, 1, 3'b001);
    sweep(64, 3);
    // R8 R9: both DMA enables
    step(0, 0, 0, 0, 0, 0, 0, 1, 3'b110);
    sweep(64, 11);
    // R10: illegal combinations, DMA wins, error sticks
    step(0, 0, 0, 0, 0, 0, 0, 1, 3'b011);
    sweep(32, 5);
    step(0, 0, 0, 0, 0, 0, 0, 1, 3'b101);
    sweep(32, 9);
    step(0, 0, 0, 0, 0, 0, 0, 1, 3'b001);
    sweep(32, 17);
    // same-cycle corners: R5 R8 R9
    step(0, 0, 0, 0, 0, 0, 0, 1, 3'b110);
    step(1, 16'h1234, 1, 16'hBEEF, 0, 1, 1, 0, 3'b000);
    step(0, 0, 1, 16'hCAFE, 1, 1, 0, 0, 3'b000);
    step(0, 0, 1, 16'h0001, 0, 0, 0, 0, 3'b000);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule